// File: doc/BRIEF.md
# Bus Target Data-Phase Controller

This block is the slave-side control for a 32-bit parallel bus that carries address and data on the same wires. All handshakes on it are active low. When the frame strobe goes low after an idle cycle, the block samples the address and the 4-bit command. If the command is a memory read or a memory write, and the address falls inside one aligned window, the block claims the cycle. It does this by pulling its device-select low after a delay that is fixed when the block is built.

After the claim, the block runs one or more data phases. Each phase completes on the first edge where both the initiator's ready and the block's target-ready are low. On writes, the bus word and its byte enables go to a local register-file port. On reads, the register-file word at the current address is driven onto the bus. The internal word address steps once per completed phase and wraps inside the window.

The transaction ends when the initiator raises the frame strobe on the last phase. In the cycle after that phase the block lets go of device-select, target-ready and the data bus. Arbitration, configuration space, parity, the wide bus extension and target-initiated termination are not part of the block. Its stop line is therefore held high.

Top module: `bus_target_ctl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), devsel_n, trdy_n and stop_n are high, ad_oe is 0 and rf_we is 0.
- R2: trdy_n and stop_n are high in the address cycle, which is the first cycle with frame_n low after a cycle with frame_n high. stop_n is high at all times.
- R3: A cycle is claimed only when the command on cbe_n is 4'b0110 (memory read) or 4'b0111 (memory write) and the address lies in [BASE_ADDR, BASE_ADDR+WIN_BYTES). For any other command or address, devsel_n and trdy_n stay high for the whole transaction.
- R4: Take the address as sampled on edge 0. Then devsel_n is low from the cycle after edge DEVSEL_DLY (0 = fast, 1 = medium, 2 = slow) until the release. trdy_n is never low while devsel_n is high.
- R5: On a write, trdy_n goes low in the same cycle as devsel_n. On a read, trdy_n is high and ad_oe is 0 in the cycle after the address edge. trdy_n first goes low in the cycle after edge max(DEVSEL_DLY,1).
- R6: A data word moves only on an edge where irdy_n and trdy_n are both low. While irdy_n is high the phase repeats, with no write and no address step.
- R7: The initiator marks the final phase by driving frame_n high while irdy_n is low. In the cycle after that phase completes, devsel_n and trdy_n are high and ad_oe is 0.
- R8: On each completed write phase, rf_we pulses and rf_wdata equals ad_in. rf_be equals ~cbe_n (bit i enables byte i, bits 8i+7:8i), and rf_addr is the current word. A phase with cbe_n = 4'hF writes nothing but still advances the word address.
- R9: On a read, ad_out carries the register word at the current word address during every cycle of the phase that has trdy_n low. The first word is address bits [AW+1:2] of the sampled address. The address steps by one per completed phase and wraps modulo the window size.
- R10: Bit 0 of the command selects the direction (1 = write, 0 = read). ad_oe is 1 only during the data phases of a claimed read.
- R11: If frame_n and irdy_n are both high while the block holds a claimed transaction, the block returns to idle. In the next cycle devsel_n and trdy_n are high and ad_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Frame strobe from the initiator |
| irdy_n | input | 1 | Initiator ready |
| cbe_n | input | 4 | Command in the address cycle, active-low byte enables in data phases |
| ad_in | input | 32 | Address/data bus as seen by the target |
| ad_out | output | 32 | Read data to drive on the bus |
| ad_oe | output | 1 | Bus drive enable for ad_out |
| devsel_n | output | 1 | Device select |
| trdy_n | output | 1 | Target ready |
| stop_n | output | 1 | Stop request, always high |
| rf_addr | output | AW | Register-file word address |
| rf_we | output | 1 | Register-file write strobe |
| rf_be | output | 4 | Register-file byte write enables |
| rf_wdata | output | 32 | Register-file write data |
| rf_rdata | input | 32 | Register-file read data for rf_addr |

## Verification
The assertions check the timing rules on every cycle:
- target-ready never goes low without device-select;
- no target-ready and no bus drive in the cycle after a read address;
- device-select, target-ready and the bus drive are released after a final or abandoned phase;
- the word address steps after each non-final phase;
- read drive never appears on a write.

Other behaviour can only be shown by the bench's scenarios:
- the exact device-select delay;
- the contents written under each mix of byte enables;
- the order of read data across wait states and window wrap;
- which commands and addresses are ignored.

// File: rtl/bus_target_pkg.sv
// Package: shared state type and command codes for the bus target.
// Assumes a 4-bit command field whose bit 0 selects write (1) or read (0).
package bus_target_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLAIM = 2'd1,
        ST_DATA  = 2'd2
    } tgt_state_e;

    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;

endpackage

// File: rtl/bus_target_decode.sv
// Address and command decode for one aligned window.
// Assumes WIN_BYTES is a power of two and BASE_ADDR is aligned to it.
// Purely combinational: evaluated on the address cycle by the FSM.
module bus_target_decode
    import bus_target_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h1000_0000,
    parameter int          WIN_BYTES = 64
) (
    input  logic [31:0] ad_in,
    input  logic [3:0]  cbe_n,
    output logic        hit
);
    localparam logic [31:0] WIN_MASK = 32'(WIN_BYTES - 1);

    logic cmd_is_mem;
    logic addr_in_win;

    // Memory read and memory write differ only in bit 0.
    always_comb cmd_is_mem = (cbe_n[3:1] == CMD_MEM_RD[3:1]);

    // Window match on the bits above the window size.
    always_comb addr_in_win = ((ad_in & ~WIN_MASK) == BASE_ADDR);

    // Claim only when both match.
    always_comb hit = cmd_is_mem && addr_in_win;

endmodule

// File: rtl/bus_target_fsm.sv
// Transaction sequencer: detects the address cycle, times the device-select
// and target-ready assertion from DEVSEL_DLY, and tracks data phases until
// the initiator's final phase or an idle bus.
// Assumes DEVSEL_DLY is 0, 1 or 2. Reads never assert target-ready in the
// cycle after the address (bus turnaround).
module bus_target_fsm
    import bus_target_pkg::*;
#(
    parameter int DEVSEL_DLY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    input  logic cmd_wr,
    input  logic hit,
    output logic start,
    output logic xfer,
    output logic last,
    output logic abort,
    output logic enter_rd,
    output logic is_wr,
    output logic devsel_n,
    output logic trdy_n
);
    localparam int             CW      = $clog2(DEVSEL_DLY + 2);
    localparam int             RD_TST  = (DEVSEL_DLY < 1) ? 1 : DEVSEL_DLY;
    localparam logic [CW-1:0]  DLY_C   = CW'(DEVSEL_DLY);
    localparam logic [CW-1:0]  WR_C    = CW'(DEVSEL_DLY);
    localparam logic [CW-1:0]  RD_C    = CW'(RD_TST);

    tgt_state_e     st;
    logic [CW-1:0]  cnt;
    logic [CW-1:0]  tstart_q;
    logic [CW-1:0]  tstart_nx;
    logic           frame_q;
    logic           wr_q;
    logic           devsel_q;
    logic           trdy_q;
    logic           claim_now;

    // Fast decode asserts device-select on the address edge itself.
    generate
        if (DEVSEL_DLY == 0) begin : g_fast
            assign claim_now = 1'b1;
        end else begin : g_delayed
            assign claim_now = 1'b0;
        end
    endgenerate

    // Target-ready start cycle depends on direction (read needs turnaround).
    always_comb tstart_nx = cmd_wr ? WR_C : RD_C;

    // Event decode for this cycle.
    always_comb begin
        start    = (st == ST_IDLE) && !frame_n && frame_q && hit;
        xfer     = (st == ST_DATA) && !irdy_n && !trdy_q;
        last     = xfer && frame_n;
        abort    = (st != ST_IDLE) && frame_n && irdy_n;
        enter_rd = (st == ST_CLAIM) && !abort && (cnt >= tstart_q) && !wr_q;
    end

    // Sequencer state, claim counter and registered handshake outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            tstart_q <= '0;
            frame_q  <= 1'b1;
            wr_q     <= 1'b0;
            devsel_q <= 1'b1;
            trdy_q   <= 1'b1;
        end else begin
            frame_q <= frame_n;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        wr_q     <= cmd_wr;
                        devsel_q <= !claim_now;
                        if (tstart_nx == '0) begin
                            st     <= ST_DATA;
                            trdy_q <= 1'b0;
                        end else begin
                            st       <= ST_CLAIM;
                            cnt      <= CW'(1);
                            tstart_q <= tstart_nx;
                        end
                    end
                end
                ST_CLAIM: begin
                    if (abort) begin
                        st       <= ST_IDLE;
                        devsel_q <= 1'b1;
                        trdy_q   <= 1'b1;
                    end else begin
                        cnt <= cnt + CW'(1);
                        if (cnt >= DLY_C) devsel_q <= 1'b0;
                        if (cnt >= tstart_q) begin
                            st     <= ST_DATA;
                            trdy_q <= 1'b0;
                        end
                    end
                end
                ST_DATA: begin
                    if (last || abort) begin
                        st       <= ST_IDLE;
                        devsel_q <= 1'b1;
                        trdy_q   <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign is_wr    = wr_q;
    assign devsel_n = devsel_q;
    assign trdy_n   = trdy_q;

    // Target-ready stays high in the address cycle.
    p_trdy_high_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> trdy_q);

    // Read: no target-ready in the cycle after the address edge.
    p_read_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !cmd_wr) |=> trdy_q);

    // Target-ready is only low while device-select is low.
    p_trdy_under_devsel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_q |-> !devsel_q);

    // Device-select released after the final phase.
    p_devsel_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (devsel_q && trdy_q));

    // Idle bus drops the claim.
    p_idle_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (devsel_q && trdy_q));

endmodule

// File: rtl/bus_target_datapath.sv
// Word address counter, register-file port and read-data drive.
// Assumes the register file returns rf_rdata for rf_addr in the same cycle.
// During a read transfer, rf_addr looks one word ahead so the next phase's
// data is registered on the transfer edge.
module bus_target_datapath #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          xfer,
    input  logic          last,
    input  logic          abort,
    input  logic          enter_rd,
    input  logic          is_wr,
    input  logic [31:0]   ad_in,
    input  logic [3:0]    cbe_n,
    input  logic [31:0]   rf_rdata,
    output logic [AW-1:0] rf_addr,
    output logic          rf_we,
    output logic [3:0]    rf_be,
    output logic [31:0]   rf_wdata,
    output logic [31:0]   ad_out,
    output logic          ad_oe
);
    logic [AW-1:0] word_q;
    logic [31:0]   ad_out_q;
    logic          oe_q;

    // Register-file port: write current word, read one ahead on read transfers.
    always_comb begin
        rf_addr  = (xfer && !is_wr) ? (word_q + AW'(1)) : word_q;
        rf_we    = xfer && is_wr && (cbe_n != 4'hF);
        rf_be    = ~cbe_n;
        rf_wdata = ad_in;
    end

    // Word address load, step and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            ad_out_q <= '0;
        end else begin
            if (start)     word_q <= ad_in[AW+1:2];
            else if (xfer) word_q <= word_q + AW'(1);
            ad_out_q <= rf_rdata;
        end
    end

    // Bus drive enable: on from the first read phase, off after the last.
    always_ff @(posedge clk) begin
        if (!rst_n)               oe_q <= 1'b0;
        else if (enter_rd)        oe_q <= 1'b1;
        else if (last || abort)   oe_q <= 1'b0;
    end

    assign ad_out = ad_out_q;
    assign ad_oe  = oe_q;

    // Each non-final phase advances the word address by one.
    p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !last) |=> (word_q == $past(word_q) + AW'(1)));

    // Drive released after the final or abandoned phase.
    p_oe_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (last || abort) |=> !oe_q);

    // Bus drive only on reads.
    p_oe_read_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> !is_wr);

endmodule

// File: rtl/bus_target_ctl.sv
// Top of the bus target: decode, sequencer and datapath.
// Assumes the bus's tri-state is resolved outside; ad_out/ad_oe form the
// target's drive of the shared address/data wires.
module bus_target_ctl #(
    parameter logic [31:0] BASE_ADDR  = 32'h1000_0000,
    parameter int          WIN_BYTES  = 64,
    parameter int          DEVSEL_DLY = 1,
    localparam int         AW         = $clog2(WIN_BYTES / 4)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_n,
    input  logic          irdy_n,
    input  logic [3:0]    cbe_n,
    input  logic [31:0]   ad_in,
    output logic [31:0]   ad_out,
    output logic          ad_oe,
    output logic          devsel_n,
    output logic          trdy_n,
    output logic          stop_n,
    output logic [AW-1:0] rf_addr,
    output logic          rf_we,
    output logic [3:0]    rf_be,
    output logic [31:0]   rf_wdata,
    input  logic [31:0]   rf_rdata
);
    logic hit, start, xfer, last, abort, enter_rd, is_wr;

    bus_target_decode #(
        .BASE_ADDR (BASE_ADDR),
        .WIN_BYTES (WIN_BYTES)
    ) u_decode (
        .ad_in (ad_in),
        .cbe_n (cbe_n),
        .hit   (hit)
    );

    bus_target_fsm #(
        .DEVSEL_DLY (DEVSEL_DLY)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .cmd_wr   (cbe_n[0]),
        .hit      (hit),
        .start    (start),
        .xfer     (xfer),
        .last     (last),
        .abort    (abort),
        .enter_rd (enter_rd),
        .is_wr    (is_wr),
        .devsel_n (devsel_n),
        .trdy_n   (trdy_n)
    );

    bus_target_datapath #(
        .AW (AW)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .xfer     (xfer),
        .last     (last),
        .abort    (abort),
        .enter_rd (enter_rd),
        .is_wr    (is_wr),
        .ad_in    (ad_in),
        .cbe_n    (cbe_n),
        .rf_rdata (rf_rdata),
        .rf_addr  (rf_addr),
        .rf_we    (rf_we),
        .rf_be    (rf_be),
        .rf_wdata (rf_wdata),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe)
    );

    // Target-initiated termination is not supported.
    assign stop_n = 1'b1;

    // Read data is only driven while the cycle is claimed.
    p_oe_under_devsel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> !devsel_n);

    // No register write outside a completed handshake.
    p_write_needs_hs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (!irdy_n && !trdy_n));

endmodule

// File: tb/sim_bus_target_ctl.sv
module sim_bus_target_ctl;
    localparam logic [31:0] BASE = 32'h1000_0000;
    localparam int          WIN  = 64;
    localparam int          DLY  = 1;
    localparam int          NW   = WIN / 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_n, irdy_n;
    logic [3:0]  cbe_n;
    logic [31:0] ad_in;
    logic [31:0] ad_out;
    logic        ad_oe, devsel_n, trdy_n, stop_n;
    logic [3:0]  rf_addr;
    logic        rf_we;
    logic [3:0]  rf_be;
    logic [31:0] rf_wdata;
    logic [31:0] rf_rdata;

    logic [31:0] mem     [NW];
    logic [31:0] exp_mem [NW];
    logic [31:0] wdat    [4];
    logic [3:0]  wbe     [4];

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  fin    = 0;

    always #2 clk = ~clk;

    bus_target_ctl #(.BASE_ADDR(BASE), .WIN_BYTES(WIN), .DEVSEL_DLY(DLY)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
        .rf_addr(rf_addr), .rf_we(rf_we), .rf_be(rf_be),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    function automatic logic [31:0] init_word(input int i);
        return (32'(i) * 32'h0101_0101) ^ 32'hA5C3_9E21;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    // Register file model attached to the target port.
    assign rf_rdata = mem[rf_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) mem[i] <= init_word(i);
        end else if (rf_we) begin
            mem[rf_addr] <= merge(mem[rf_addr], rf_wdata, rf_be);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_n = 1'b1; irdy_n = 1'b1;
            cbe_n = 4'($urandom); ad_in = $urandom;
            chk(devsel_n && trdy_n && !ad_oe && stop_n, "R7 idle outputs", {29'd0, devsel_n, trdy_n, ad_oe}, 32'h6);
        end
    endtask

    task automatic cmp_mem(input string req);
        for (int i = 0; i < NW; i++)
            chk(mem[i] === exp_mem[i], req, mem[i], exp_mem[i]);
    endtask

    // One initiator transaction of n phases, wait states up to maxwait.
    task automatic txn(input logic [3:0] cmd, input logic [31:0] addr, input int n,
                       input int maxwait);
        bit hit = (cmd[3:1] == 3'b011) && (addr[31:6] == BASE[31:6]);
        bit wr  = cmd[0];
        int tst = wr ? DLY : ((DLY < 1) ? 1 : DLY);
        int woff = int'(addr[5:2]);
        int w = 0;
        int k = 0;
        int waitc;
        bit irdy_on = 0;
        bit done = 0;
        @(negedge clk);
        chk(trdy_n && stop_n, "R2 trdy/stop high in address cycle", {30'd0, trdy_n, stop_n}, 32'h3);
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
        waitc = $urandom_range(maxwait, 0);
        while (!done && k < 60) begin
            @(negedge clk);
            k++;
            if (hit) begin
                chk(devsel_n == ((k >= DLY + 1) ? 1'b0 : 1'b1), "R4 devsel timing", {31'd0, devsel_n}, 32'(k));
                chk(trdy_n == ((k >= tst + 1) ? 1'b0 : 1'b1), wr ? "R5 write trdy timing" : "R5 read trdy timing",
                    {31'd0, trdy_n}, 32'(k));
                if (!wr && k == 1) chk(!ad_oe, "R5 read turnaround no drive", {31'd0, ad_oe}, 32'd0);
                if (wr) chk(!ad_oe, "R10 no drive on write", {31'd0, ad_oe}, 32'd0);
            end else begin
                chk(devsel_n && trdy_n && !ad_oe, "R3 unclaimed stays silent", {29'd0, devsel_n, trdy_n, ad_oe}, 32'h6);
            end
            if (!irdy_on) begin
                if (waitc == 0) irdy_on = 1; else waitc--;
            end
            irdy_n  = !irdy_on;
            frame_n = (irdy_on && w == n - 1) ? 1'b1 : 1'b0;
            ad_in   = wr ? wdat[w] : $urandom;
            cbe_n   = ~wbe[w];
            if (irdy_on && (hit ? !trdy_n : (k >= 4))) begin
                if (hit && !wr) begin
                    chk(ad_oe, "R10 read drive enabled", {31'd0, ad_oe}, 32'd1);
                    chk(ad_out === exp_mem[(woff + w) % NW], "R9 read data", ad_out, exp_mem[(woff + w) % NW]);
                end
                if (hit && wr)
                    exp_mem[(woff + w) % NW] = merge(exp_mem[(woff + w) % NW], wdat[w], wbe[w]);
                if (w == n - 1) done = 1;
                else begin
                    w++; irdy_on = 0; waitc = $urandom_range(maxwait, 0);
                end
            end
        end
        chk(done, "R6 transaction completes", 32'(w), 32'(n - 1));
        @(negedge clk);
        chk(devsel_n && trdy_n && !ad_oe, "R7 release after final phase", {29'd0, devsel_n, trdy_n, ad_oe}, 32'h6);
        frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'($urandom); ad_in = $urandom;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            n_fail++;
            $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24680));
        rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF; ad_in = '0;
        for (int i = 0; i < NW; i++) exp_mem[i] = init_word(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk(devsel_n && trdy_n && stop_n && !ad_oe && !rf_we, "R1 reset state",
            {27'd0, devsel_n, trdy_n, stop_n, ad_oe, rf_we}, 32'h1C);

        // R8: burst write with full, partial and empty byte enables
        wdat[0] = 32'h1111_2222; wbe[0] = 4'hF;
        wdat[1] = 32'h3333_4444; wbe[1] = 4'h5;
        wdat[2] = 32'h5555_6666; wbe[2] = 4'h0;
        wdat[3] = 32'h7777_8888; wbe[3] = 4'h8;
        txn(4'b0111, BASE + 32'h8, 4, 0);
        cmp_mem("R8 write with byte enables");

        // R9: read back with wait states, then read across window wrap
        for (int i = 0; i < 4; i++) wbe[i] = 4'hF;
        txn(4'b0110, BASE + 32'h8, 4, 2);
        txn(4'b0110, BASE + 32'h38, 4, 1);
        cmp_mem("R10 read leaves contents unchanged");

        // R3: wrong command inside window, memory command outside window
        wdat[0] = 32'hDEAD_BEEF;
        txn(4'b0010, BASE + 32'h4, 1, 0);
        txn(4'b0011, BASE + 32'h4, 1, 0);
        txn(4'b0111, BASE + 32'h40, 2, 0);
        txn(4'b0111, BASE - 32'h4, 1, 0);
        cmp_mem("R3 unclaimed commands write nothing");

        // R11: claimed then bus goes idle before any data phase
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = BASE; cbe_n = 4'b0111;
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b1;
        @(negedge clk);
        chk(devsel_n && trdy_n && !ad_oe, "R11 idle bus releases claim", {29'd0, devsel_n, trdy_n, ad_oe}, 32'h6);
        idle(3);

        // R6: single write with long initiator wait, then back-to-back read
        wdat[0] = 32'hCAFE_F00D; wbe[0] = 4'hF;
        txn(4'b0111, BASE + 32'h3C, 1, 3);
        txn(4'b0110, BASE + 32'h3C, 1, 3);
        cmp_mem("R6 write lands once after wait states");

        // Random mix of claimed and unclaimed transactions
        for (int t = 0; t < 60; t++) begin
            int sel = $urandom_range(5, 0);
            logic [3:0]  cmd;
            logic [31:0] a;
            int n = $urandom_range(4, 1);
            for (int i = 0; i < 4; i++) begin
                wdat[i] = $urandom;
                wbe[i]  = ($urandom_range(4, 0) == 0) ? 4'h0 : 4'($urandom);
            end
            a = BASE + {26'd0, 4'($urandom), 2'b00};
            case (sel)
                0, 1:    cmd = 4'b0111;
                2, 3:    cmd = 4'b0110;
                4:       cmd = 4'b0010;
                default: begin cmd = 4'b0110; a = a + 32'h100; end
            endcase
            txn(cmd, a, n, 2);
            if ($urandom_range(1, 0) == 1) idle($urandom_range(2, 1));
        end
        cmp_mem("R8 random write contents");

        fin = 1;
        summary();
        $finish;
    end
endmodule